// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block carries out the data operations of a classic 8-bit accumulator processor. The caller supplies an operation code, a left operand (the accumulator or an index register, selected outside the block), a memory operand and a memory-target bit. Each cycle the block returns an 8-bit result and write enables for the register and memory paths. That output is combinational. A registered status byte holds the carry, zero, interrupt-disable, decimal, break, overflow and negative flags. Arithmetic takes its carry-in from that byte.

The flag register is updated on each rising clock edge from three sources, in rising priority. The first is the flag changes of the current operation. The second is an explicit set or clear command. The third is a whole-byte restore from the status input, as used when the status is pulled from a stack. Subtraction uses the inverted-borrow carry convention. Arithmetic is always binary, whatever the decimal flag holds.

Top module: `acc_alu_top`

## Requirements
- R1: Reset is synchronous and active high. While reset is held and after it is released, `stat_out` reads 0x20 with all flags clear. The byte layout is carry bit 0, zero bit 1, interrupt-disable bit 2, decimal bit 3, break bit 4, constant one bit 5, overflow bit 6, negative bit 7. With `op_code` 0 (no operation), neither write enable is raised.
- R2: Add (code 2) gives `res_out` = L + M + C mod 256 and raises `wr_reg`. Carry is set when the unsigned sum exceeds 255. Overflow is set when the signed sum falls outside -128..127. Zero and negative follow the result.
- R3: Subtract (code 3) gives L + ~M + C mod 256 and raises `wr_reg`. Carry becomes 1 when no borrow occurred (L - M - (1 - C) >= 0). Overflow is set when the signed difference falls outside -128..127. Zero and negative follow the result.
- R4: Compare (code 4) raises no write enable and leaves overflow unchanged. It sets carry when L >= M unsigned, sets zero when L equals M, and sets negative from bit 7 of (L - M) mod 256.
- R5: AND, OR and XOR (codes 5, 6, 7) combine L with M, raise `wr_reg`, update zero and negative, and leave carry and overflow unchanged.
- R6: Bit test (code 8) raises no write enable and leaves carry unchanged. Zero is set when (L & M) is 0, negative takes M bit 7 and overflow takes M bit 6.
- R7: Increment and decrement (codes 9, 10) wrap modulo 256, update zero and negative, and leave carry unchanged. With `use_mem` = 0 they act on L and raise `wr_reg`. With `use_mem` = 1 they act on M and raise `wr_mem`.
- R8: Shift left (code 11) moves bit 7 into carry and fills bit 0 with 0. Shift right (code 12) moves bit 0 into carry and fills bit 7 with 0. Both update zero and negative, and choose their source and target by `use_mem` as in R7.
- R9: Rotate left (code 13) and rotate right (code 14) work like R8, but the vacated bit takes the carry held before the operation.
- R10: Transfer (code 1) passes L to `res_out`, raises `wr_reg` and updates zero and negative. Move (code 15) changes no flag. With `use_mem` = 0 it outputs M with `wr_reg`; with `use_mem` = 1 it outputs L with `wr_mem`. The two write enables are never raised together.
- R11: `flag_cmd` codes: 1 sets carry, 2 clears carry, 3 sets interrupt-disable, 4 clears interrupt-disable, 5 sets decimal, 6 clears decimal, 7 clears overflow, 0 does nothing. Each takes effect at the next clock edge.
- R12: When a flag command and an operation that updates flags fall in the same cycle, the command decides the flag it names. The operation's other flag updates still take effect.
- R13: With `stat_load` = 1, every bit of `stat_in` is copied into the status byte at the next edge, except bit 5, which still reads 1. This overrides any operation and flag command in the same cycle.
- R14: The decimal flag has no effect: add and subtract give the binary results of R2 and R3 while it is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 4 | Operation select (codes in R2 to R10) |
| use_mem | input | 1 | Shift, increment, decrement and move act on memory when 1 |
| flag_cmd | input | 3 | Explicit flag set/clear command (R11) |
| stat_load | input | 1 | Restore the status byte from `stat_in` |
| stat_in | input | 8 | Status byte to restore |
| reg_in | input | 8 | Left operand: accumulator or index register |
| mem_in | input | 8 | Memory operand |
| res_out | output | 8 | Operation result, valid when a write enable is high |
| wr_reg | output | 1 | Write `res_out` to the register |
| wr_mem | output | 1 | Write `res_out` to memory |
| stat_out | output | 8 | Current status byte |

## Verification
Two things can change the same flag in one cycle: the flag update of an arithmetic or shift operation and an explicit flag command (or a full status restore). The bench forces this case on purpose. One example is an add that produces a carry-out while the same cycle clears carry. Another is a restore driven together with an operation. Background random traffic also mixes commands and restores into operations. A behavioural per-cycle model applies the operation first, then the command, then the restore. The status byte is compared against that model after every edge.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int MSB    = DATA_W - 1;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [3:0] {
        OP_NONE = 4'd0,
        OP_XFER = 4'd1,
        OP_ADC  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_ORA  = 4'd6,
        OP_EOR  = 4'd7,
        OP_BIT  = 4'd8,
        OP_INC  = 4'd9,
        OP_DEC  = 4'd10,
        OP_ASL  = 4'd11,
        OP_LSR  = 4'd12,
        OP_ROL  = 4'd13,
        OP_ROR  = 4'd14,
        OP_MOVE = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        FC_NOP = 3'd0,
        FC_SEC = 3'd1,
        FC_CLC = 3'd2,
        FC_SEI = 3'd3,
        FC_CLI = 3'd4,
        FC_SED = 3'd5,
        FC_CLD = 3'd6,
        FC_CLV = 3'd7
    } fcmd_e;

    // Status byte, bit 7 first: the layout is restored bit for bit.
    typedef struct packed {
        logic n;
        logic v;
        logic one;
        logic b;
        logic d;
        logic i;
        logic z;
        logic c;
    } stat_t;

    localparam stat_t STAT_RST = stat_t'(8'h20);

    typedef struct packed {
        logic set_c;
        logic set_zn;
        logic set_v;
        logic c;
        logic z;
        logic v;
        logic n;
    } flag_upd_t;

    typedef struct packed {
        word_t     res;
        logic      wr_reg;
        logic      wr_mem;
        flag_upd_t fl;
    } alu_res_t;

    function automatic logic is_zero(input word_t w);
        return (w == '0);
    endfunction

    function automatic logic sign_of(input word_t w);
        return w[MSB];
    endfunction

    // Signed overflow: result sign differs from both addend signs.
    function automatic logic add_ovf(input word_t a, input word_t b, input word_t s);
        word_t t;
        t = (s ^ a) & (s ^ b);
        return t[MSB];
    endfunction

    function automatic logic is_shift(input op_e op);
        return (op == OP_ASL) || (op == OP_LSR) || (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic is_arith(input op_e op);
        return (op == OP_ADC) || (op == OP_SBC) || (op == OP_CMP);
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
`timescale 1ns/1ps
module acc_alu_arith
    import acc_alu_pkg::*;
(
    input  op_e      op,
    input  word_t    lhs,
    input  word_t    mem,
    input  logic     cin,
    output alu_res_t ar
);

    localparam int SUM_W = DATA_W + 1;

    word_t            opnd;
    logic             ci;
    logic [SUM_W-1:0] sum;
    word_t            res;

    // Subtract and compare add the inverted operand; compare forces carry-in.
    assign opnd = (op == OP_ADC) ? mem : ~mem;
    assign ci   = (op == OP_CMP) ? 1'b1 : cin;
    assign sum  = {1'b0, lhs} + {1'b0, opnd} + {{DATA_W{1'b0}}, ci};
    assign res  = sum[DATA_W-1:0];

    always_comb begin
        ar           = '0;
        ar.res       = res;
        ar.wr_reg    = (op != OP_CMP);
        ar.fl.set_c  = 1'b1;
        ar.fl.set_zn = 1'b1;
        ar.fl.set_v  = (op != OP_CMP);
        ar.fl.c      = sum[DATA_W];
        ar.fl.z      = is_zero(res);
        ar.fl.n      = sign_of(res);
        ar.fl.v      = add_ovf(lhs, opnd, res);
    end

endmodule

// File: rtl/acc_alu_logic.sv
`timescale 1ns/1ps
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  op_e      op,
    input  logic     use_mem,
    input  word_t    lhs,
    input  word_t    mem,
    output alu_res_t lr
);

    word_t src;
    word_t tst;

    assign src = use_mem ? mem : lhs;
    assign tst = lhs & mem;

    always_comb begin
        lr = '0;
        case (op)
            OP_XFER: begin
                lr.res       = lhs;
                lr.wr_reg    = 1'b1;
                lr.fl.set_zn = 1'b1;
            end
            OP_AND: begin
                lr.res       = lhs & mem;
                lr.wr_reg    = 1'b1;
                lr.fl.set_zn = 1'b1;
            end
            OP_ORA: begin
                lr.res       = lhs | mem;
                lr.wr_reg    = 1'b1;
                lr.fl.set_zn = 1'b1;
            end
            OP_EOR: begin
                lr.res       = lhs ^ mem;
                lr.wr_reg    = 1'b1;
                lr.fl.set_zn = 1'b1;
            end
            OP_INC: begin
                lr.res       = src + 1'b1;
                lr.wr_reg    = !use_mem;
                lr.wr_mem    = use_mem;
                lr.fl.set_zn = 1'b1;
            end
            OP_DEC: begin
                lr.res       = src - 1'b1;
                lr.wr_reg    = !use_mem;
                lr.wr_mem    = use_mem;
                lr.fl.set_zn = 1'b1;
            end
            OP_MOVE: begin
                lr.res    = use_mem ? lhs : mem;
                lr.wr_reg = !use_mem;
                lr.wr_mem = use_mem;
            end
            default: ;
        endcase

        if (op == OP_BIT) begin
            lr.fl.set_zn = 1'b1;
            lr.fl.set_v  = 1'b1;
            lr.fl.z      = is_zero(tst);
            lr.fl.n      = mem[MSB];
            lr.fl.v      = mem[MSB-1];
        end else begin
            lr.fl.z = is_zero(lr.res);
            lr.fl.n = sign_of(lr.res);
        end
    end

endmodule

// File: rtl/acc_alu_shift.sv
`timescale 1ns/1ps
module acc_alu_shift
    import acc_alu_pkg::*;
(
    input  op_e      op,
    input  logic     use_mem,
    input  word_t    lhs,
    input  word_t    mem,
    input  logic     cin,
    output alu_res_t sr
);

    word_t src;
    word_t up;
    word_t dn;
    logic  fill;
    logic  left;

    assign src  = use_mem ? mem : lhs;
    assign fill = ((op == OP_ROL) || (op == OP_ROR)) ? cin : 1'b0;
    assign left = (op == OP_ASL) || (op == OP_ROL);

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        if (g == 0) begin : g_lo
            assign up[g] = fill;
        end else begin : g_lo_n
            assign up[g] = src[g-1];
        end
        if (g == DATA_W - 1) begin : g_hi
            assign dn[g] = fill;
        end else begin : g_hi_n
            assign dn[g] = src[g+1];
        end
    end

    always_comb begin
        sr           = '0;
        sr.res       = left ? up : dn;
        sr.wr_reg    = !use_mem;
        sr.wr_mem    = use_mem;
        sr.fl.set_c  = 1'b1;
        sr.fl.set_zn = 1'b1;
        sr.fl.c      = left ? src[MSB] : src[0];
        sr.fl.z      = is_zero(sr.res);
        sr.fl.n      = sign_of(sr.res);
    end

endmodule

// File: rtl/acc_alu_status.sv
`timescale 1ns/1ps
module acc_alu_status
    import acc_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_upd_t upd,
    input  fcmd_e     cmd,
    input  logic      load,
    input  stat_t     load_val,
    output stat_t     q
);

    stat_t nxt;

    always_comb begin
        nxt = q;
        // Operation result first.
        if (upd.set_c) nxt.c = upd.c;
        if (upd.set_zn) begin
            nxt.z = upd.z;
            nxt.n = upd.n;
        end
        if (upd.set_v) nxt.v = upd.v;
        // Explicit command overrides the bit it names.
        case (cmd)
            FC_SEC:  nxt.c = 1'b1;
            FC_CLC:  nxt.c = 1'b0;
            FC_SEI:  nxt.i = 1'b1;
            FC_CLI:  nxt.i = 1'b0;
            FC_SED:  nxt.d = 1'b1;
            FC_CLD:  nxt.d = 1'b0;
            FC_CLV:  nxt.v = 1'b0;
            default: ;
        endcase
        // Full restore wins over everything.
        if (load) nxt = load_val;
        nxt.one = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= STAT_RST;
        else     q <= nxt;
    end

    AST_PULL_EXACT: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == ($past(load_val) | stat_t'(8'h20))));                 // R13
    AST_SEC_SETS: assert property (@(posedge clk) disable iff (rst)
        (cmd == FC_SEC && !load) |=> q.c);                                    // R11
    AST_CLV_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd == FC_CLV && !load) |=> !q.v);                                   // R11
    AST_CMD_BEATS_OP: assert property (@(posedge clk) disable iff (rst)
        (cmd == FC_CLC && upd.set_c && upd.c && !load) |=> !q.c);             // R12

endmodule

// File: rtl/acc_alu_top.sv
`timescale 1ns/1ps
module acc_alu_top
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_code,
    input  logic              use_mem,
    input  logic [2:0]        flag_cmd,
    input  logic              stat_load,
    input  logic [DATA_W-1:0] stat_in,
    input  logic [DATA_W-1:0] reg_in,
    input  logic [DATA_W-1:0] mem_in,
    output logic [DATA_W-1:0] res_out,
    output logic              wr_reg,
    output logic              wr_mem,
    output logic [DATA_W-1:0] stat_out
);

    op_e      op;
    fcmd_e    cmd;
    stat_t    st_q;
    alu_res_t ar;
    alu_res_t lr;
    alu_res_t sr;
    alu_res_t sel;

    assign op  = op_e'(op_code);
    assign cmd = fcmd_e'(flag_cmd);

    acc_alu_arith u_arith (
        .op  (op),
        .lhs (reg_in),
        .mem (mem_in),
        .cin (st_q.c),
        .ar  (ar)
    );

    acc_alu_logic u_logic (
        .op      (op),
        .use_mem (use_mem),
        .lhs     (reg_in),
        .mem     (mem_in),
        .lr      (lr)
    );

    acc_alu_shift u_shift (
        .op      (op),
        .use_mem (use_mem),
        .lhs     (reg_in),
        .mem     (mem_in),
        .cin     (st_q.c),
        .sr      (sr)
    );

    always_comb begin
        if (is_arith(op))      sel = ar;
        else if (is_shift(op)) sel = sr;
        else                   sel = lr;
    end

    acc_alu_status u_status (
        .clk      (clk),
        .rst      (rst),
        .upd      (sel.fl),
        .cmd      (cmd),
        .load     (stat_load),
        .load_val (stat_t'(stat_in)),
        .q        (st_q)
    );

    assign res_out  = sel.res;
    assign wr_reg   = sel.wr_reg;
    assign wr_mem   = sel.wr_mem;
    assign stat_out = st_q;

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CMP) |-> (!wr_reg && !wr_mem));                             // R4
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_reg, wr_mem}));                                          // R10
    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_INC || op == OP_DEC) && cmd == FC_NOP && !stat_load)
        |=> $stable(stat_out[0]));                                            // R7
    AST_BIT_COPIES: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BIT && cmd == FC_NOP && !stat_load)
        |=> (stat_out[7] == $past(mem_in[7]) && stat_out[6] == $past(mem_in[6]))); // R6

endmodule

// File: tb/sim_acc_alu_top.sv
`timescale 1ns/1ps
module sim_acc_alu_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_code = '0;
    logic       use_mem = 1'b0;
    logic [2:0] flag_cmd = '0;
    logic       stat_load = 1'b0;
    logic [7:0] stat_in = '0;
    logic [7:0] reg_in = '0;
    logic [7:0] mem_in = '0;
    logic [7:0] res_out;
    logic       wr_reg;
    logic       wr_mem;
    logic [7:0] stat_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference flags
    int mc = 0, mz = 0, mi = 0, md = 0, mb = 0, mv = 0, mn = 0;

    always #4 clk = ~clk;   // 125 MHz

    acc_alu_top u0 (
        .clk(clk), .rst(rst), .op_code(op_code), .use_mem(use_mem),
        .flag_cmd(flag_cmd), .stat_load(stat_load), .stat_in(stat_in),
        .reg_in(reg_in), .mem_in(mem_in), .res_out(res_out),
        .wr_reg(wr_reg), .wr_mem(wr_mem), .stat_out(stat_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int packed_stat();
        return mn*128 + mv*64 + 32 + mb*16 + md*8 + mi*4 + mz*2 + mc;
    endfunction

    function automatic int sgn(input int x);
        return (x > 127) ? x - 256 : x;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5, 6, 7: return "R5";
            8: return "R6";
            9, 10: return "R7";
            11, 12: return "R8";
            13, 14: return "R9";
            0: return "R1";
            default: return "R10";
        endcase
    endfunction

    task automatic run(input int op, input int um, input int fc, input int ld,
                       input int sv, input int l, input int m, input string tag);
        int r, s, ss, src, ewr, ewm, zn;
        int nc, nz, nv, nn, ni, nd, nb;
        @(negedge clk);
        op_code = op[3:0]; use_mem = um[0]; flag_cmd = fc[2:0];
        stat_load = ld[0]; stat_in = sv[7:0]; reg_in = l[7:0]; mem_in = m[7:0];
        r = 0; ewr = 0; ewm = 0; zn = 0;
        nc = mc; nz = mz; nv = mv; nn = mn; ni = mi; nd = md; nb = mb;
        src = um ? m : l;
        case (op)
            1: begin r = l; ewr = 1; zn = 1; end
            2: begin
                s = l + m + mc; r = s & 255; nc = (s > 255);
                ss = sgn(l) + sgn(m) + mc; nv = (ss > 127 || ss < -128);
                ewr = 1; zn = 1;
            end
            3: begin
                s = l - m - (1 - mc); r = s & 255; nc = (s >= 0);
                ss = sgn(l) - sgn(m) - (1 - mc); nv = (ss > 127 || ss < -128);
                ewr = 1; zn = 1;
            end
            4: begin nc = (l >= m); nz = (l == m); nn = (((l - m) & 255) >= 128); end
            5: begin r = l & m; ewr = 1; zn = 1; end
            6: begin r = l | m; ewr = 1; zn = 1; end
            7: begin r = l ^ m; ewr = 1; zn = 1; end
            8: begin nz = ((l & m) == 0); nn = (m >= 128); nv = (m / 64) % 2; end
            9:  begin r = (src + 1) % 256;   ewr = !um; ewm = um; zn = 1; end
            10: begin r = (src + 255) % 256; ewr = !um; ewm = um; zn = 1; end
            11: begin nc = (src >= 128); r = (src * 2) % 256; ewr = !um; ewm = um; zn = 1; end
            12: begin nc = src % 2; r = src / 2; ewr = !um; ewm = um; zn = 1; end
            13: begin nc = (src >= 128); r = (src * 2 + mc) % 256; ewr = !um; ewm = um; zn = 1; end
            14: begin nc = src % 2; r = src / 2 + mc * 128; ewr = !um; ewm = um; zn = 1; end
            15: begin r = um ? l : m; ewr = !um; ewm = um; end
            default: ;
        endcase
        if (zn) begin nz = (r == 0); nn = (r >= 128); end
        case (fc)
            1: nc = 1;
            2: nc = 0;
            3: ni = 1;
            4: ni = 0;
            5: nd = 1;
            6: nd = 0;
            7: nv = 0;
            default: ;
        endcase
        if (ld) begin
            nc = sv % 2; nz = (sv / 2) % 2; ni = (sv / 4) % 2; nd = (sv / 8) % 2;
            nb = (sv / 16) % 2; nv = (sv / 64) % 2; nn = (sv / 128) % 2;
        end
        #1;
        chk(req_of(op), "wr_reg", int'(wr_reg), ewr);
        chk(req_of(op), "wr_mem", int'(wr_mem), ewm);
        if (ewr || ewm) chk(req_of(op), "res_out", int'(res_out), r);
        @(posedge clk);
        #1;
        mc = nc; mz = nz; mv = nv; mn = nn; mi = ni; md = nd; mb = nb;
        chk(tag, "stat_out", int'(stat_out), packed_stat());
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "stat_out in reset", int'(stat_out), 32'h20);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "stat_out after reset", int'(stat_out), 32'h20);
        chk("R1", "wr_reg idle", int'(wr_reg), 0);
        chk("R1", "wr_mem idle", int'(wr_mem), 0);
        run(0, 0, 0, 0, 0, 8'h12, 8'h34, "R1");

        // R2 add
        run(2, 0, 0, 0, 0, 8'h50, 8'h50, "R2");
        run(2, 0, 0, 0, 0, 8'hFF, 8'h01, "R2");
        run(2, 0, 0, 0, 0, 8'h10, 8'h20, "R2");
        run(2, 0, 0, 0, 0, 8'h80, 8'h80, "R2");
        // R3 subtract
        run(0, 0, 1, 0, 0, 0, 0, "R11");
        run(3, 0, 0, 0, 0, 8'h50, 8'hF0, "R3");
        run(3, 0, 0, 0, 0, 8'h00, 8'h01, "R3");
        run(3, 0, 0, 0, 0, 8'h80, 8'h01, "R3");
        // R4 compare
        run(4, 0, 0, 0, 0, 8'h40, 8'h40, "R4");
        run(4, 0, 0, 0, 0, 8'h10, 8'h20, "R4");
        run(4, 0, 0, 0, 0, 8'hF0, 8'h01, "R4");
        // R5 logic
        run(5, 0, 0, 0, 0, 8'hF0, 8'h0F, "R5");
        run(6, 0, 0, 0, 0, 8'h80, 8'h01, "R5");
        run(7, 0, 0, 0, 0, 8'h5A, 8'hA5, "R5");
        // R6 bit test
        run(8, 0, 0, 0, 0, 8'h00, 8'hC0, "R6");
        run(8, 0, 0, 0, 0, 8'h01, 8'h01, "R6");
        // R7 inc/dec
        run(0, 0, 1, 0, 0, 0, 0, "R11");
        run(9, 1, 0, 0, 0, 8'h00, 8'hFF, "R7");
        run(10, 0, 0, 0, 0, 8'h00, 8'h33, "R7");
        run(9, 0, 0, 0, 0, 8'h7F, 8'h00, "R7");
        // R8 shifts
        run(11, 0, 0, 0, 0, 8'h80, 8'h00, "R8");
        run(12, 1, 0, 0, 0, 8'h00, 8'h03, "R8");
        // R9 rotates
        run(0, 0, 1, 0, 0, 0, 0, "R11");
        run(13, 0, 0, 0, 0, 8'h40, 8'h00, "R9");
        run(0, 0, 1, 0, 0, 0, 0, "R11");
        run(14, 1, 0, 0, 0, 8'h00, 8'h02, "R9");
        // R10 transfer / move
        run(1, 0, 0, 0, 0, 8'h00, 8'hFF, "R10");
        run(15, 0, 0, 0, 0, 8'h11, 8'h00, "R10");
        run(15, 1, 0, 0, 0, 8'h99, 8'h22, "R10");
        // R11 commands
        run(0, 0, 3, 0, 0, 0, 0, "R11");
        run(0, 0, 5, 0, 0, 0, 0, "R11");
        run(0, 0, 4, 0, 0, 0, 0, "R11");
        run(2, 0, 0, 0, 0, 8'h7F, 8'h7F, "R2");
        run(0, 0, 7, 0, 0, 0, 0, "R11");
        run(0, 0, 2, 0, 0, 0, 0, "R11");
        // R14 decimal ignored (D is set)
        run(2, 0, 0, 0, 0, 8'h09, 8'h01, "R14");
        run(3, 0, 0, 0, 0, 8'h10, 8'h01, "R14");
        run(0, 0, 6, 0, 0, 0, 0, "R11");
        // R12 same-cycle command and operation
        run(2, 0, 2, 0, 0, 8'hFF, 8'h02, "R12");
        run(12, 0, 1, 0, 0, 8'h02, 8'h00, "R12");
        run(8, 0, 7, 0, 0, 8'h00, 8'h40, "R12");
        // R13 restore overrides
        run(2, 0, 1, 1, 8'hD5, 8'hFF, 8'hFF, "R13");
        run(0, 0, 0, 1, 8'h00, 0, 0, "R13");
        run(0, 0, 0, 1, 8'hDF, 0, 0, "R13");

        seed = 32'h1ACE_B00C;
        for (int i = 0; i < 600; i++) begin
            int op, um, fc, ld, sv, l, m;
            string tag;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >>> 17); seed = seed ^ (seed << 5);
            op = i % 16;
            um = (seed >>> 3) & 1;
            l  = (seed >>> 4) & 255;
            m  = (seed >>> 12) & 255;
            fc = (((seed >>> 20) & 3) == 0) ? ((seed >>> 22) & 7) : 0;
            ld = (((seed >>> 25) & 15) == 0) ? 1 : 0;
            sv = (seed >>> 8) & 255;
            tag = ld ? "R13" : (fc != 0 ? "R12" : req_of(op));
            run(op, um, fc, ld, sv, l, m, tag);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule